// File: doc/BRIEF.md
# Linked-Descriptor SD Data Mover

This block carries the data phase of an SD transfer between system memory and the card's word-wide data port. Software builds a linked list of four-word descriptors in memory, programs the address of the first one, the total byte count and the block size, and pulses a start input. The engine then fetches one descriptor at a time. It moves that descriptor's share of the data in 32-bit words and writes the descriptor's status word back to memory to hand ownership back to software. It then either follows the link or finishes.

Two directions are supported. In transmit, words are read from memory and pushed onto the card-bound stream. In receive, the engine first waits for the card to report data, then pops words from the card stream and writes them to memory. Completion is reported through a nine-bit status vector and a data-complete flag. A memory error response instead raises an abnormal-completion flag and marks the affected descriptor with its error bit.

Top module: `sdma_chain_dma`

## Requirements
- R1: A start pulse is accepted only while idle with `dma_enable` high, `byte_count` non-zero and `block_size` non-zero. Otherwise `busy` stays low and no memory request is made.
- R2: In receive (`dir_write` = 0), an accepted start makes no memory request until `card_ready` is high. `busy` is high while it waits.
- R3: Each descriptor is fetched with four word reads, at its address +0, +4, +8 and +12, in that order. The four words are status, buffer size in bytes, buffer address and next-descriptor address.
- R4: A size field of 0, or one above `MAX_BUF_BYTES`, counts as `MAX_BUF_BYTES`. A descriptor moves min(size, remaining bytes) bytes, rounded up to whole 32-bit words.
- R5: The buffer address is used with bits 1:0 forced to zero. Successive words go to consecutive word addresses.
- R6: In transmit, memory words appear on `tx_data` in buffer order. In receive, words taken from `rx_data` are written to memory in arrival order.
- R7: After a descriptor's data is moved, its status word is written back to the descriptor's address with bit 31 (owned) cleared and every other bit unchanged.
- R8: The remaining byte count drops by the bytes moved, saturating at zero. The walk ends after a descriptor whose status bit 2 (last) is set, or when the remaining count reaches zero. Otherwise it continues at the next-descriptor address.
- R9: On normal completion, `dma_sts` bit 8 (summary) is set together with bit 0 for transmit or bit 1 for receive, and `data_complete` rises. All of these clear on the next accepted start.
- R10: An error response on any memory access stops the walk. The current descriptor is written back with bit 30 (error) set and bit 31 cleared, and `abnormal` is set. `dma_sts` and `data_complete` stay clear.
- R11: `mem_req` and its address, direction and write data hold steady until `mem_gnt`. `tx_valid` and `tx_data` hold steady until `tx_ready`.
- R12: `done` pulses for exactly one cycle when a run ends, and `busy` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| dma_enable | input | 1 | DMA enable from global control |
| dir_write | input | 1 | 1 = transmit (memory to card), 0 = receive |
| card_ready | input | 1 | Card has read data available |
| desc_base | input | 32 | Address of the first descriptor |
| byte_count | input | 32 | Total bytes to move |
| block_size | input | 32 | Card block size; must be non-zero to start |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Card-bound word valid |
| tx_data | output | 32 | Card-bound word |
| tx_ready | input | 1 | Card accepts the word |
| rx_valid | input | 1 | Card word valid |
| rx_data | input | 32 | Card word |
| rx_ready | output | 1 | Engine takes the card word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| dma_sts | output | 9 | Bit 8 summary, bit 1 receive done, bit 0 transmit done |
| data_complete | output | 1 | Data phase finished normally |
| abnormal | output | 1 | Run stopped on a memory error |

## Verification
A two-descriptor chain is swept over every pairing of 1 to 5 size words with 1 to 6 words of byte count, in both directions. This separates runs that stop on the exhausted count from runs that stop on the last flag, and shows whether the second descriptor is written back only when visited. The card side throttles both streams with irregular ready/valid patterns, so the handshake holding is exercised. Further runs cover a zero size, an oversized size field, an odd size that rounds up, an unaligned buffer address, the receive wait on card readiness, the three refused-start conditions, and error responses during data movement and during descriptor fetch.

// File: rtl/sdma_pkg.sv
// Shared types and bit positions for the linked-descriptor data mover.
// Assumes 32-bit descriptor words and byte addresses.
package sdma_pkg;

    localparam int WORD_W = 32;

    // descriptor status bits the engine reads or rewrites
    localparam int ST_OWN  = 31;
    localparam int ST_ERR  = 30;
    localparam int ST_LAST = 2;

    // completion vector bit positions
    localparam int DS_SUM = 8;
    localparam int DS_RX  = 1;
    localparam int DS_TX  = 0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CARD,
        S_FETCH,
        S_FETCH_W,
        S_CALC,
        S_MRD,
        S_MRD_W,
        S_TXPUSH,
        S_RXPOP,
        S_MWR,
        S_MWR_W,
        S_WBACK,
        S_WBACK_W
    } walk_state_t;

endpackage

// File: rtl/sdma_len_calc.sv
// Per-descriptor length: clamps the size field to the buffer limit
// (zero also means the limit), takes the smaller of that and the bytes
// still owed, and rounds the result up to whole words.
// Assumes remaining is non-zero whenever the result is used.
module sdma_len_calc #(
    parameter int MAX_BUF_BYTES = 8192,
    localparam int CW = $clog2(MAX_BUF_BYTES / 4 + 1)
) (
    input  logic [31:0]   size_field,
    input  logic [31:0]   remaining,
    output logic [31:0]   nbytes,
    output logic [CW-1:0] nwords
);
    localparam logic [31:0] MAXB = 32'(MAX_BUF_BYTES);

    logic [31:0] eff_size;
    logic [31:0] rounded;

    // clamp size, pick the shorter length, round up to words
    always_comb begin
        eff_size = (size_field == 32'd0 || size_field > MAXB) ? MAXB : size_field;
        nbytes   = (eff_size < remaining) ? eff_size : remaining;
        rounded  = (nbytes + 32'd3) >> 2;
        nwords   = CW'(rounded);
    end
endmodule

// File: rtl/sdma_beat_ctr.sv
// Down-counter of words left in the current descriptor's buffer.
// Assumes load and dec never coincide.
module sdma_beat_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt;

    // load at descriptor start, count down per moved word
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/sdma_chain_dma.sv
// Linked-descriptor data mover. Walks four-word descriptors, moves each
// buffer between memory and the card streams word by word, writes the
// status word back with ownership cleared and follows the link until
// the last flag or the byte count ends the run.
// Assumes one outstanding memory request; every granted request gets
// exactly one response in a later cycle.
module sdma_chain_dma
    import sdma_pkg::*;
#(
    parameter int MAX_BUF_BYTES = 8192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dma_enable,
    input  logic        dir_write,
    input  logic        card_ready,
    input  logic [31:0] desc_base,
    input  logic [31:0] byte_count,
    input  logic [31:0] block_size,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rsp_valid,
    input  logic        mem_rsp_err,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [31:0] tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [31:0] rx_data,
    output logic        rx_ready,
    output logic        busy,
    output logic        done,
    output logic [8:0]  dma_sts,
    output logic        data_complete,
    output logic        abnormal
);
    localparam int CW = $clog2(MAX_BUF_BYTES / 4 + 1);

    walk_state_t state;
    logic [1:0]  widx;
    logic [31:0] cur_desc, rem, nbytes_q, buf_ptr, data_q;
    logic [31:0] dsc_status, dsc_size, dsc_addr, dsc_next;
    logic        dir_q, err_seen;

    logic [31:0]   calc_bytes;
    logic [CW-1:0] calc_words;
    logic          ctr_load, ctr_dec, beat_last;
    logic [31:0]   wb_word, rem_next;
    logic          start_ok;

    sdma_len_calc #(.MAX_BUF_BYTES(MAX_BUF_BYTES)) u_len (
        .size_field (dsc_size),
        .remaining  (rem),
        .nbytes     (calc_bytes),
        .nwords     (calc_words)
    );

    sdma_beat_ctr #(.CW(CW)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (calc_words),
        .dec      (ctr_dec),
        .last     (beat_last)
    );

    // request qualification, beat events, write-back word, count update
    always_comb begin
        start_ok = start && dma_enable && byte_count != 32'd0 && block_size != 32'd0;
        ctr_load = (state == S_CALC);
        ctr_dec  = (state == S_TXPUSH && tx_ready) ||
                   (state == S_MWR_W && mem_rsp_valid && !mem_rsp_err);
        wb_word          = dsc_status;
        wb_word[ST_OWN]  = 1'b0;
        if (err_seen) wb_word[ST_ERR] = 1'b1;
        rem_next = (rem > nbytes_q) ? rem - nbytes_q : 32'd0;
    end

    // memory and stream port drive from the walk state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = 32'd0;
        mem_wdata = 32'd0;
        case (state)
            S_FETCH: begin mem_req = 1'b1; mem_addr = cur_desc + {28'd0, widx, 2'b00}; end
            S_MRD:   begin mem_req = 1'b1; mem_addr = buf_ptr; end
            S_MWR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = buf_ptr; mem_wdata = data_q; end
            S_WBACK: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_desc; mem_wdata = wb_word; end
            default: ;
        endcase
        tx_valid = (state == S_TXPUSH);
        tx_data  = data_q;
        rx_ready = (state == S_RXPOP);
        busy     = (state != S_IDLE);
    end

    // descriptor walk sequencer with completion reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;   widx <= 2'd0;      cur_desc <= 32'd0;
            rem <= 32'd0;      nbytes_q <= 32'd0; buf_ptr <= 32'd0;
            data_q <= 32'd0;   dsc_status <= 32'd0; dsc_size <= 32'd0;
            dsc_addr <= 32'd0; dsc_next <= 32'd0; dir_q <= 1'b0;
            err_seen <= 1'b0;  done <= 1'b0;      dma_sts <= 9'd0;
            data_complete <= 1'b0; abnormal <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start_ok) begin
                    cur_desc <= desc_base;  rem <= byte_count;  dir_q <= dir_write;
                    err_seen <= 1'b0;       widx <= 2'd0;       dsc_status <= 32'd0;
                    dma_sts <= 9'd0;        data_complete <= 1'b0; abnormal <= 1'b0;
                    state <= dir_write ? S_FETCH : S_CARD;
                end
                S_CARD:  if (card_ready) state <= S_FETCH;
                S_FETCH: if (mem_gnt) state <= S_FETCH_W;
                S_FETCH_W: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        err_seen <= 1'b1;
                        state    <= S_WBACK;
                    end else begin
                        case (widx)
                            2'd0: dsc_status <= mem_rdata;
                            2'd1: dsc_size   <= mem_rdata;
                            2'd2: dsc_addr   <= mem_rdata;
                            default: dsc_next <= mem_rdata;
                        endcase
                        widx  <= widx + 2'd1;
                        state <= (widx == 2'd3) ? S_CALC : S_FETCH;
                    end
                end
                S_CALC: begin
                    nbytes_q <= calc_bytes;
                    buf_ptr  <= dsc_addr & ~32'd3;
                    state    <= dir_q ? S_MRD : S_RXPOP;
                end
                S_MRD: if (mem_gnt) state <= S_MRD_W;
                S_MRD_W: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        err_seen <= 1'b1;
                        state    <= S_WBACK;
                    end else begin
                        data_q <= mem_rdata;
                        state  <= S_TXPUSH;
                    end
                end
                S_TXPUSH: if (tx_ready) begin
                    buf_ptr <= buf_ptr + 32'd4;
                    state   <= beat_last ? S_WBACK : S_MRD;
                end
                S_RXPOP: if (rx_valid) begin
                    data_q <= rx_data;
                    state  <= S_MWR;
                end
                S_MWR: if (mem_gnt) state <= S_MWR_W;
                S_MWR_W: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        err_seen <= 1'b1;
                        state    <= S_WBACK;
                    end else begin
                        buf_ptr <= buf_ptr + 32'd4;
                        state   <= beat_last ? S_WBACK : S_RXPOP;
                    end
                end
                S_WBACK: if (mem_gnt) state <= S_WBACK_W;
                S_WBACK_W: if (mem_rsp_valid) begin
                    rem <= rem_next;
                    if (err_seen || mem_rsp_err) begin
                        abnormal <= 1'b1;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else if (dsc_status[ST_LAST] || rem_next == 32'd0) begin
                        dma_sts[DS_SUM] <= 1'b1;
                        if (dir_q) dma_sts[DS_TX] <= 1'b1;
                        else       dma_sts[DS_RX] <= 1'b1;
                        data_complete <= 1'b1;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        cur_desc   <= dsc_next;
                        widx       <= 2'd0;
                        dsc_status <= 32'd0;
                        state      <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdma_chain_dma_chk.sv
// Port-level protocol and completion checks for the data mover.
module sdma_chain_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        dma_enable,
    input logic        dir_write,
    input logic        card_ready,
    input logic [31:0] byte_count,
    input logic [31:0] block_size,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_gnt,
    input logic        tx_valid,
    input logic [31:0] tx_data,
    input logic        tx_ready,
    input logic        rx_ready,
    input logic        busy,
    input logic        done,
    input logic [8:0]  dma_sts,
    input logic        data_complete,
    input logic        abnormal
);
    a_r1_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (!dma_enable || byte_count == 32'd0 || block_size == 32'd0) |=> !busy);

    a_r2_wait_card: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && dma_enable && byte_count != 32'd0 && block_size != 32'd0
        && !dir_write && !card_ready |=> busy && !mem_req);

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_sts[1:0]));

    a_r9_summary_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dma_sts[8] |-> (dma_sts[0] || dma_sts[1]) && data_complete);

    a_r10_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
        abnormal |-> !dma_sts[8] && !data_complete);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !tx_valid && !rx_ready);
endmodule

bind sdma_chain_dma sdma_chain_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dma_enable(dma_enable),
    .dir_write(dir_write), .card_ready(card_ready), .byte_count(byte_count),
    .block_size(block_size), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .busy(busy), .done(done), .dma_sts(dma_sts),
    .data_complete(data_complete), .abnormal(abnormal)
);

// File: tb/sdma_chain_dma_test.sv
module sdma_chain_dma_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, dma_enable = 1'b0, dir_write = 1'b0, card_ready = 1'b0;
    logic [31:0] desc_base = '0, byte_count = '0, block_size = '0;
    logic mem_req, mem_we, mem_gnt = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
    logic [31:0] tx_data, rx_data = '0;
    logic busy, done, data_complete, abnormal;
    logic [8:0] dma_sts;

    sdma_chain_dma uut (.*);

    always #5 clk = ~clk;

    logic [31:0] bmem [0:4095];
    logic [31:0] tx_log [0:4095];
    logic [31:0] acc_addr [0:15];
    logic        acc_we [0:15];
    int tx_n = 0, rx_idx = 0, acc_n = 0, cyc = 0, run_id = 0;
    int vecs = 0, fails = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    bit finished = 0;

    function automatic logic [31:0] pat(input int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0000_9E37);
    endfunction
    function automatic logic [31:0] rxw(input int j);
        return (32'h5A00_0000 ^ (32'(run_id) << 16)) + 32'(j);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // memory model: grant at one falling edge, answer at the next
    initial begin
        bit pend = 0;
        logic [31:0] pdata = '0;
        logic perr = 1'b0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1; mem_rdata = pdata; mem_rsp_err = perr; pend = 0;
            end else if (mem_req) begin
                mem_gnt = 1'b1;
                perr = (mem_addr == err_addr);
                if (mem_we && !perr) bmem[mem_addr[13:2]] = mem_wdata;
                pdata = bmem[mem_addr[13:2]];
                if (acc_n < 16) begin acc_addr[acc_n] = mem_addr; acc_we[acc_n] = mem_we; end
                acc_n++;
                pend = 1;
            end
        end
    end

    // card model: throttled stream handshakes
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = (cyc % 4) != 1;
            if (tx_valid && tx_ready) begin
                if (tx_n < 4096) tx_log[tx_n] = tx_data;
                tx_n++;
            end
            rx_valid = (cyc % 3) != 0;
            rx_data  = rxw(rx_idx);
            if (rx_valid && rx_ready) rx_idx++;
        end
    end

    task automatic init_mem();
        for (int i = 0; i < 4096; i++) bmem[i] = pat(i);
    endtask

    task automatic put_desc(input logic [31:0] a, st, sz, ba, nx);
        bmem[a[13:2]] = st; bmem[a[13:2]+1] = sz; bmem[a[13:2]+2] = ba; bmem[a[13:2]+3] = nx;
    endtask

    task automatic kick(input logic dir, input logic [31:0] base, bytes, blk, input logic en);
        @(negedge clk);
        run_id++; tx_n = 0; rx_idx = 0; acc_n = 0;
        dir_write = dir; desc_base = base; byte_count = bytes; block_size = blk;
        dma_enable = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 40000) begin @(negedge clk); t++; end
        chk(done === 1'b1, "R12 run end pulse", 32'(done), 32'd1);
    endtask

    // watchdog
    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        localparam logic [31:0] D0 = 32'h3000, D1 = 32'h3010, B0 = 32'h0400, B1 = 32'h0800;
        localparam logic [31:0] ST0 = 32'h8000_0018, ST1 = 32'h8000_0014;
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !tx_valid && !rx_ready && !done, "reset idle", {28'd0, busy, mem_req, tx_valid, rx_ready}, 32'd0);
        chk(dma_sts == 9'd0 && !data_complete && !abnormal, "reset flags", {22'd0, dma_sts, data_complete}, 32'd0);

        // R1: refused starts
        put_desc(D0, ST1, 32'd8, B0, 32'd0);
        kick(1'b1, D0, 32'd8, 32'd512, 1'b0);
        repeat (6) @(negedge clk);
        chk(!busy && acc_n == 0, "R1 enable low", 32'(acc_n), 32'd0);
        kick(1'b1, D0, 32'd0, 32'd512, 1'b1);
        repeat (6) @(negedge clk);
        chk(!busy && acc_n == 0, "R1 zero byte count", 32'(acc_n), 32'd0);
        kick(1'b1, D0, 32'd8, 32'd0, 1'b1);
        repeat (6) @(negedge clk);
        chk(!busy && acc_n == 0, "R1 zero block size", 32'(acc_n), 32'd0);

        // sweep: two-descriptor chain, both directions, all size/count pairings
        for (int d = 0; d < 2; d++) begin
            for (int s = 1; s <= 5; s++) begin
                for (int r = 1; r <= 6; r++) begin
                    int m0, m1, rem, mism;
                    logic [31:0] e;
                    init_mem();
                    put_desc(D0, ST0, 32'(s * 4), B0, D1);
                    put_desc(D1, ST1, 32'd8, B1, 32'd0);
                    card_ready = 1'b1;
                    kick(d[0], D0, 32'(r * 4), 32'd512, 1'b1);
                    wait_done();
                    m0 = (s < r) ? s : r;
                    rem = r - m0;
                    m1 = (rem == 0) ? 0 : ((rem < 2) ? rem : 2);
                    mism = 0;
                    for (int k = 0; k < m0 + m1; k++) begin
                        int wi;
                        wi = (k < m0) ? (int'(B0[13:2]) + k) : (int'(B1[13:2]) + k - m0);
                        if (d == 1) begin if (tx_log[k] !== pat(wi)) mism++; end
                        else begin if (bmem[wi] !== rxw(k)) mism++; end
                    end
                    if (d == 0 && bmem[int'(B0[13:2]) + m0] !== pat(int'(B0[13:2]) + m0)) mism++;
                    chk(mism == 0, "R6 sweep data order", 32'(mism), 32'd0);
                    chk((d == 1 ? tx_n : rx_idx) == m0 + m1, "R8 sweep word total",
                        32'(d == 1 ? tx_n : rx_idx), 32'(m0 + m1));
                    chk(bmem[D0[13:2]] == (ST0 & 32'h7FFF_FFFF), "R7 first write-back",
                        bmem[D0[13:2]], ST0 & 32'h7FFF_FFFF);
                    e = (rem > 0) ? (ST1 & 32'h7FFF_FFFF) : ST1;
                    chk(bmem[D1[13:2]] == e, "R8 second descriptor visited iff count left", bmem[D1[13:2]], e);
                    chk(dma_sts == (d == 1 ? 9'h101 : 9'h102) && data_complete && !abnormal,
                        "R9 completion flags", {23'd0, dma_sts}, (d == 1 ? 32'h101 : 32'h102));
                end
            end
        end

        // R3, R4 rounding, R8 saturation: size 6 then size 8 last, count 10
        init_mem();
        put_desc(D0, 32'h8000_0010, 32'd6, B0, D1);
        put_desc(D1, ST1, 32'd8, B1, 32'd0);
        kick(1'b1, D0, 32'd10, 32'd512, 1'b1);
        wait_done();
        @(negedge clk);
        chk(!done && !busy, "R12 single-cycle pulse", {30'd0, done, busy}, 32'd0);
        chk(acc_addr[0] == D0 && acc_addr[1] == D0 + 4 && acc_addr[2] == D0 + 8 && acc_addr[3] == D0 + 12
            && !acc_we[0] && !acc_we[1] && !acc_we[2] && !acc_we[3], "R3 fetch order", acc_addr[3], D0 + 12);
        chk(tx_n == 3 && tx_log[2] == pat(int'(B1[13:2])), "R4 odd size rounds up", 32'(tx_n), 32'd3);

        // R4: zero size means maximum
        init_mem();
        put_desc(D0, ST1, 32'd0, 32'd0, 32'd0);
        kick(1'b1, D0, 32'h3000, 32'd512, 1'b1);
        wait_done();
        chk(tx_n == 2048 && tx_log[2047] == pat(2047), "R4 zero size is max", 32'(tx_n), 32'd2048);
        // R4: oversized clamps
        init_mem();
        put_desc(D0, ST1, 32'h0010_0000, 32'd0, 32'd0);
        kick(1'b1, D0, 32'h3000, 32'd512, 1'b1);
        wait_done();
        chk(tx_n == 2048, "R4 oversize clamps", 32'(tx_n), 32'd2048);
        // R4: count shorter than zero-size buffer
        init_mem();
        put_desc(D0, ST1, 32'd0, 32'd0, 32'd0);
        kick(1'b1, D0, 32'd40, 32'd512, 1'b1);
        wait_done();
        chk(tx_n == 10, "R4 count limits zero size", 32'(tx_n), 32'd10);

        // R5: unaligned buffer address
        init_mem();
        put_desc(D0, ST1, 32'd8, 32'h0403, 32'd0);
        kick(1'b1, D0, 32'd8, 32'd512, 1'b1);
        wait_done();
        chk(tx_log[0] == pat(32'h100) && tx_log[1] == pat(32'h101), "R5 low address bits dropped", tx_log[0], pat(32'h100));

        // R2: receive waits for card data
        init_mem();
        put_desc(D0, ST1, 32'd8, B0, 32'd0);
        card_ready = 1'b0;
        kick(1'b0, D0, 32'd8, 32'd512, 1'b1);
        repeat (8) @(negedge clk);
        chk(busy && acc_n == 0, "R2 no access before card ready", 32'(acc_n), 32'd0);
        card_ready = 1'b1;
        wait_done();
        chk(bmem[int'(B0[13:2])] == rxw(0) && bmem[int'(B0[13:2]) + 1] == rxw(1), "R2 receive after ready",
            bmem[int'(B0[13:2])], rxw(0));

        // R10: error during buffer read
        init_mem();
        put_desc(D0, ST1, 32'd16, B0, 32'd0);
        err_addr = B0 + 32'd8;
        kick(1'b1, D0, 32'd16, 32'd512, 1'b1);
        wait_done();
        err_addr = 32'hFFFF_FFFF;
        chk(tx_n == 2, "R10 walk stops at error", 32'(tx_n), 32'd2);
        chk(bmem[D0[13:2]] == 32'h4000_0014, "R10 error write-back", bmem[D0[13:2]], 32'h4000_0014);
        chk(abnormal && dma_sts == 9'd0 && !data_complete, "R10 abnormal flags", {22'd0, dma_sts, abnormal}, 32'd1);

        // R10: error during descriptor fetch
        init_mem();
        put_desc(D0, ST1, 32'd16, B0, 32'd0);
        err_addr = D0 + 32'd4;
        kick(1'b1, D0, 32'd16, 32'd512, 1'b1);
        wait_done();
        err_addr = 32'hFFFF_FFFF;
        chk(tx_n == 0 && bmem[D0[13:2]] == 32'h4000_0014, "R10 fetch error write-back", bmem[D0[13:2]], 32'h4000_0014);

        // R9: flags clear on next accepted start
        init_mem();
        put_desc(D0, ST1, 32'd4, B0, 32'd0);
        kick(1'b1, D0, 32'd4, 32'd512, 1'b1);
        chk(!abnormal && dma_sts == 9'd0, "R9 flags cleared at start", {22'd0, dma_sts, abnormal}, 32'd0);
        wait_done();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule